// File: doc/BRIEF.md
# Per-Channel Configuration Latch Bank

This block holds the configuration of four receive/transmit channels in a small addressed register file. A host drives a 4-bit address, an 8-bit data byte and an active-low write strobe; on every rising clock edge with the strobe low, the byte lands in the row selected by the address. Each channel owns three rows: a receiver row whose bits are decoded into framer mode, framing-character choice, decoder mode, decoder enable and receive clock source; a transmitter row; and a dynamic row.

The channel addresses are not contiguous: channel 2 starts one code later than a plain stride of three, which leaves codes 6, 13 and 15 unused. Code 14 is a broadcast slot that loads the dynamic rows of all four channels at once. A host that never needs independent control can park the address on 14 and hold the strobe low, so the data pins act as live global controls that reach the outputs one clock later.

Top module: `cfg_latch_bank`

## Requirements
- R1: While rst_n is low and after its release, each channel's receiver row reads framer mode 2'b10 with framing-character select, decoder mode, decoder enable and receive clock select all 1; every transmitter and dynamic row reads 8'h00.
- R2: A write to address 0, 3, 7 or 10 loads the receiver row of channel 0, 1, 2 or 3, visible one clock later; data bits [1:0] give framer mode, bit 2 framing-character select, bit 3 decoder mode, bit 4 decoder enable, bit 5 receive clock select; bits 7:6 are not stored.
- R3: A write to address 1, 4, 8 or 11 loads the full byte into the transmitter row of channel 0, 1, 2 or 3, shown on tx_ctl bits [8c+7:8c], one clock later.
- R4: A write to address 2, 5, 9 or 12 loads the full byte into the dynamic row of channel 0, 1, 2 or 3, shown on dyn_ctl bits [8c+7:8c], one clock later.
- R5: A write to address 14 loads the same byte into all four dynamic rows one clock later and leaves receiver and transmitter rows unchanged.
- R6: While the address stays at 14 and wr_n stays low, every dynamic output equals the data byte present at the previous clock edge, cycle after cycle.
- R7: While wr_n is high, no row changes whatever the address and data.
- R8: A write to address 6, 13 or 15 changes no row.
- R9: A write to one channel's row leaves every row of the other channels, and the other rows of the same channel, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 4 | Row address |
| din | input | 8 | Write data |
| rx_fmode | output | 8 | Framer mode, 2 bits per channel, channel c at [2c+1:2c] |
| rx_fchar | output | 4 | Framing-character select, one bit per channel |
| rx_dmode | output | 4 | Decoder mode, one bit per channel |
| rx_dec_en | output | 4 | Decoder enable, one bit per channel |
| rx_clksel | output | 4 | Receive clock source select, one bit per channel |
| tx_ctl | output | 32 | Transmitter rows, channel c at [8c+7:8c] |
| dyn_ctl | output | 32 | Dynamic rows, channel c at [8c+7:8c] |

## Verification
Every row is a single register stage, so a write presented before a rising edge is due on the outputs right after that edge. The bench drives address, data and strobe on the falling edge, lets one rising edge pass, and compares all outputs of all four channels against its own model on the next falling edge. For the held broadcast, each falling edge both checks that the dynamic outputs carry the byte driven half a period before the last rising edge and then presents a new byte, so the one-clock lag is confirmed on every cycle of the run. Rows that must stay unchanged are read at the same point after the ignored stimulus.

// File: rtl/cfg_latch_bank.sv
module cfg_latch_bank #(
  parameter int AW = 4,
  parameter int DW = 8,
  parameter int BCAST_ADDR = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     din,
  output logic [7:0]        rx_fmode,
  output logic [3:0]        rx_fchar,
  output logic [3:0]        rx_dmode,
  output logic [3:0]        rx_dec_en,
  output logic [3:0]        rx_clksel,
  output logic [4*DW-1:0]   tx_ctl,
  output logic [4*DW-1:0]   dyn_ctl
);
  localparam int NCH = 4;
  localparam int RXW = 6;
  localparam logic [RXW-1:0] RX_INIT = 6'b111110;
  localparam logic [AW-1:0]  A_BC = AW'(BCAST_ADDR);

  wire wr    = !wr_n;
  wire bcast = wr && (addr == A_BC);
  wire unused_hit = wr && (addr == AW'(6) || addr == AW'(13) || addr == AW'(15));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int BASE = c * 3 + ((c >= 2) ? 1 : 0);
    localparam logic [AW-1:0] A_RX  = AW'(BASE);
    localparam logic [AW-1:0] A_TX  = AW'(BASE + 1);
    localparam logic [AW-1:0] A_DYN = AW'(BASE + 2);

    logic [RXW-1:0] rx_q;
    logic [DW-1:0]  tx_q, dyn_q;

    wire hit_rx  = wr && (addr == A_RX);
    wire hit_tx  = wr && (addr == A_TX);
    wire hit_dyn = wr && (addr == A_DYN);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rx_q  <= RX_INIT;
        tx_q  <= '0;
        dyn_q <= '0;
      end else begin
        if (hit_rx)           rx_q  <= din[RXW-1:0];
        if (hit_tx)           tx_q  <= din;
        if (hit_dyn || bcast) dyn_q <= din;
      end
    end

    assign rx_fmode[2*c +: 2] = rx_q[1:0];
    assign rx_fchar[c]        = rx_q[2];
    assign rx_dmode[c]        = rx_q[3];
    assign rx_dec_en[c]       = rx_q[4];
    assign rx_clksel[c]       = rx_q[5];
    assign tx_ctl[DW*c +: DW]  = tx_q;
    assign dyn_ctl[DW*c +: DW] = dyn_q;

    AST_RX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_n && addr == A_RX) |=> (rx_fmode[2*c +: 2] == $past(din[1:0]) && rx_clksel[c] == $past(din[5]))); // R2
    AST_TX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_n && addr == A_TX) |=> tx_ctl[DW*c +: DW] == $past(din)); // R3
    AST_DYN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_n && addr == A_DYN) |=> dyn_ctl[DW*c +: DW] == $past(din)); // R4
    AST_BCAST_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_n && addr == A_BC) |=> (dyn_ctl[DW*c +: DW] == $past(din) && $stable(tx_ctl[DW*c +: DW]))); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_n |=> ($stable(tx_ctl[DW*c +: DW]) && $stable(dyn_ctl[DW*c +: DW]) && $stable(rx_fmode[2*c +: 2]))); // R7
    AST_UNUSED_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      unused_hit |=> ($stable(tx_ctl[DW*c +: DW]) && $stable(dyn_ctl[DW*c +: DW]) && $stable(rx_dec_en[c]))); // R8
  end
endmodule

// File: tb/cfg_latch_bank_tb_top.sv
module cfg_latch_bank_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, wr_n = 1;
  logic [3:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0]  rx_fmode;
  logic [3:0]  rx_fchar, rx_dmode, rx_dec_en, rx_clksel;
  logic [31:0] tx_ctl, dyn_ctl;

  int checks = 0, errors = 0;
  logic [5:0] exp_rx [4];
  logic [7:0] exp_tx [4];
  logic [7:0] exp_dyn [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_latch_bank dut_i (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .addr(addr), .din(din),
    .rx_fmode(rx_fmode), .rx_fchar(rx_fchar), .rx_dmode(rx_dmode),
    .rx_dec_en(rx_dec_en), .rx_clksel(rx_clksel), .tx_ctl(tx_ctl), .dyn_ctl(dyn_ctl)
  );

  function automatic int base_of(input int ch);
    case (ch)
      0: return 0;
      1: return 3;
      2: return 7;
      default: return 10;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int c = 0; c < 4; c++) begin
      chk(req, {26'd0, rx_clksel[c], rx_dec_en[c], rx_dmode[c], rx_fchar[c], rx_fmode[2*c +: 2]},
          {26'd0, exp_rx[c]});
      chk(req, {24'd0, tx_ctl[8*c +: 8]}, {24'd0, exp_tx[c]});
      chk(req, {24'd0, dyn_ctl[8*c +: 8]}, {24'd0, exp_dyn[c]});
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < 4; c++) begin
      exp_rx[c] = 6'b111110; exp_tx[c] = 8'h00; exp_dyn[c] = 8'h00;
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; din = d; wr_n = 0;
    @(negedge clk);
    wr_n = 1; din = ~d;
  endtask

  task automatic t_reset();
    model_reset();
    @(negedge clk);
    check_all("R1 during reset");
    rst_n = 1;
    @(negedge clk);
    @(negedge clk);
    check_all("R1 after release");
  endtask

  task automatic t_rx_rows();
    logic [7:0] v;
    for (int c = 0; c < 4; c++) begin
      v = 8'hC0 | 8'(c * 9 + 1);
      wr(4'(base_of(c)), v);
      exp_rx[c] = v[5:0];
      check_all("R2 rx row");
    end
    wr(4'(base_of(1)), 8'hFF);
    exp_rx[1] = 6'h3F;
    check_all("R2 rx all ones, R9 isolation");
  endtask

  task automatic t_tx_rows();
    for (int c = 0; c < 4; c++) begin
      wr(4'(base_of(c) + 1), 8'hA0 + 8'(c));
      exp_tx[c] = 8'hA0 + 8'(c);
      check_all("R3 tx row, R9");
    end
  endtask

  task automatic t_dyn_rows();
    for (int c = 0; c < 4; c++) begin
      wr(4'(base_of(c) + 2), 8'h5A ^ 8'(c << 4));
      exp_dyn[c] = 8'h5A ^ 8'(c << 4);
      check_all("R4 dyn row, R9");
    end
  endtask

  task automatic t_bcast();
    wr(4'd14, 8'h3C);
    for (int c = 0; c < 4; c++) exp_dyn[c] = 8'h3C;
    check_all("R5 broadcast");
    wr(4'(base_of(2) + 2), 8'h81);
    exp_dyn[2] = 8'h81;
    check_all("R4 per-channel after broadcast");
  endtask

  task automatic t_bcast_hold();
    logic [7:0] prev;
    @(negedge clk);
    addr = 4'd14; wr_n = 0; din = 8'h11; prev = 8'h11;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      for (int c = 0; c < 4; c++) exp_dyn[c] = prev;
      check_all("R6 held broadcast");
      prev = 8'(8'h27 * (i + 2));
      din = prev;
    end
    @(negedge clk);
    for (int c = 0; c < 4; c++) exp_dyn[c] = prev;
    wr_n = 1;
    check_all("R6 held broadcast last");
  endtask

  task automatic t_no_write();
    @(negedge clk);
    wr_n = 1;
    for (int a = 0; a < 16; a++) begin
      addr = 4'(a); din = 8'(a * 37);
      @(negedge clk);
    end
    check_all("R7 strobe high");
  endtask

  task automatic t_unused();
    wr(4'd6, 8'hEE);
    check_all("R8 addr 6");
    wr(4'd13, 8'h00);
    check_all("R8 addr 13");
    wr(4'd15, 8'h55);
    check_all("R8 addr 15");
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_rx_rows();
    t_tx_rows();
    t_dyn_rows();
    t_bcast();
    t_bcast_hold();
    t_no_write();
    t_unused();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule